// File: doc/BRIEF.md
# Direction Alignment Scorer

This block rates, pixel by pixel, how closely an edge stream agrees with one fixed orientation. Each incoming pixel carries a 2-bit orientation code and an edge flag. The code is turned into a weight that falls off with the circular distance from the block's chosen orientation. The weights are then summed over a 3x3 window made of the current pixel, the two pixels before it and the same three positions one and two lines earlier. Only pixels whose edge flag is set keep this local value. Every other pixel gets zero.

Over a frame the block counts edge pixels and adds up the gated local values. On the last pixel of the frame it divides the sum by the count to get a frame mean. That mean scales every score of the following frame: each score is the local value divided by the mean. The division runs on a multi-cycle divider, so the input is held off with a ready signal while a result is being worked out. Exactly one score leaves for every pixel accepted.

Top module: `align_score_top`

## Requirements
- R1: With the chosen orientation code C (default 1) and pixel code d, the circular distance is min((d-C) mod 4, (C-d) mod 4). Distance 0 gives weight 8, distance 1 gives weight 4 and distance 2 gives weight 1.
- R2: For the pixel at stream position n of a frame (n=0 is the pixel with `in_sof`), the local value is the sum of the weights at positions n-r*LINE_W-c for r and c each in {0,1,2}. A position before the frame start counts as 0. LINE_W defaults to 8.
- R3: A pixel with `in_edge` low has local value 0, so its score is 0.
- R4: `out_score` equals floor(local value / mean), where the mean is the value computed at the end of the previous frame.
- R5: Within a frame the edge-pixel count saturates at 255 and the sum of gated local values saturates at 65535. Both restart from zero at the pixel with `in_sof`, and that pixel is included.
- R6: On the pixel with `in_eof` (included), a nonzero count sets the mean to floor(sum/count), clamped to the range 1..255. A zero count leaves the mean unchanged.
- R7: After reset the mean is 1, so the scores of the first frame equal their local values.
- R8: After reset `in_ready` is high and `out_valid` is low. A pixel is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` then stays low, and 7 rising edges after the accepting edge `out_valid` is high for one cycle with the score while `in_ready` goes high again.
- R9: Pixel data presented while `in_ready` is low is ignored and changes no later score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Pixel present on the input fields |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_dir | input | 2 | Orientation code of the pixel |
| in_edge | input | 1 | Pixel lies on an edge |
| in_sof | input | 1 | First pixel of a frame |
| in_eof | input | 1 | Last pixel of a frame |
| out_valid | output | 1 | Score present, one-cycle pulse |
| out_score | output | 7 | Normalised alignment score |

## Verification
The assertions take for granted that every frame opens with a pixel marked `in_sof` and closes with one marked `in_eof`. They also take for granted that the divider is only started when `in_ready` is high. The stimulus always marks frame boundaries this way. While a division is busy it drives random junk on all input fields with `in_valid` high, then drops `in_valid` in the same cycle that `in_ready` returns. This exercises the stall without ever handing the block a pixel it should take.

// File: rtl/asc_pkg.sv
// Shared helpers for the alignment scorer.
// Assumes orientation codes form a closed circle of num_dir steps.
package asc_pkg;

    // Circular distance between two orientation codes.
    function automatic int circ_dist(int a, int b, int num_dir);
        int d;
        d = (a - b + num_dir) % num_dir;
        if (2 * d > num_dir) begin
            d = num_dir - d;
        end
        return d;
    endfunction

endpackage

// File: rtl/asc_weight.sv
// Maps a pixel orientation code to a weight by its circular distance from
// the chosen orientation. Purely combinational. Assumes W_CENTRE is the
// largest weight and fits WGT_W bits.
module asc_weight #(
    parameter int DIR_W     = 2,
    parameter int ALIGN_DIR = 1,
    parameter int W_CENTRE  = 8,
    parameter int W_NEAR    = 4,
    parameter int W_FAR     = 1,
    parameter int WGT_W     = 4
) (
    input  logic [DIR_W-1:0] dir_code,
    output logic [WGT_W-1:0] weight
);
    localparam int NUM_DIR = 1 << DIR_W;

    logic [WGT_W-1:0] lut [NUM_DIR];

    // One table entry per orientation code, computed at elaboration.
    for (genvar g = 0; g < NUM_DIR; g++) begin : g_lut
        localparam int DIST = asc_pkg::circ_dist(g, ALIGN_DIR, NUM_DIR);
        localparam int WV   = (DIST == 0) ? W_CENTRE : ((DIST == 1) ? W_NEAR : W_FAR);
        assign lut[g] = WGT_W'(WV);
    end

    // Table lookup for the incoming pixel.
    assign weight = lut[dir_code];

endmodule

// File: rtl/asc_window.sv
// 3x3 neighbourhood sum of weights in stream order: two line-long delays
// build a vertical sum, two single-pixel delays of that sum build the
// horizontal sum. History counts as zero at the frame-start pixel.
// Assumes accept marks exactly one pixel per cycle at most.
module asc_window #(
    parameter int LINE_W  = 8,
    parameter int WGT_W   = 4,
    parameter int W_MAX   = 8,
    parameter int LOCAL_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               sof,
    input  logic               edge_flag,
    input  logic [WGT_W-1:0]   weight,
    output logic [LOCAL_W-1:0] local_val
);
    localparam int DEPTH  = 2 * LINE_W;
    localparam int VSUM_W = $clog2(3 * W_MAX + 1);

    logic [WGT_W-1:0]   line_q [DEPTH];
    logic [VSUM_W-1:0]  vcol_q [2];
    logic [WGT_W-1:0]   up1, up2;
    logic [VSUM_W-1:0]  left1, left2, vsum;
    logic [LOCAL_W-1:0] hsum;

    // Select history, forcing zeros on the first pixel of a frame.
    always_comb begin
        up1   = sof ? '0 : line_q[LINE_W-1];
        up2   = sof ? '0 : line_q[DEPTH-1];
        left1 = sof ? '0 : vcol_q[0];
        left2 = sof ? '0 : vcol_q[1];
        vsum  = VSUM_W'(weight) + VSUM_W'(up1) + VSUM_W'(up2);
        hsum  = LOCAL_W'(vsum) + LOCAL_W'(left1) + LOCAL_W'(left2);
    end

    // Keep the window value only at edge pixels.
    assign local_val = edge_flag ? hsum : '0;

    // Shift the line delay on each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
        end else if (accept) begin
            line_q[0] <= weight;
            for (int k = 1; k < DEPTH; k++) line_q[k] <= sof ? '0 : line_q[k-1];
        end
    end

    // Shift the two-entry delay of vertical sums on each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcol_q[0] <= '0;
            vcol_q[1] <= '0;
        end else if (accept) begin
            vcol_q[0] <= vsum;
            vcol_q[1] <= left1;
        end
    end

    // R2: the frame-start pixel sees no history from the previous frame.
    p_sof_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sof) |-> (local_val == (edge_flag ? LOCAL_W'(weight) : '0)));

endmodule

// File: rtl/asc_frame_stats.sv
// Counts edge pixels and sums gated local values over a frame with
// saturation, and at the last pixel turns them into a mean for the next
// frame. Assumes sof and eof mark the first and last accepted pixels.
module asc_frame_stats #(
    parameter int CNT_W   = 8,
    parameter int ACC_W   = 16,
    parameter int MEAN_W  = 8,
    parameter int LOCAL_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               sof,
    input  logic               eof,
    input  logic               edge_flag,
    input  logic [LOCAL_W-1:0] local_val,
    output logic [MEAN_W-1:0]  mean
);
    localparam logic [ACC_W-1:0] MEAN_MAX = ACC_W'((1 << MEAN_W) - 1);

    logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_nx;
    logic [ACC_W-1:0]  acc_q, acc_base, acc_nx, q_full, divisor;
    logic [ACC_W:0]    acc_sum;
    logic [MEAN_W-1:0] mean_q, mean_nx;

    // Next count and sum, restarting at frame start and saturating.
    always_comb begin
        cnt_base = sof ? '0 : cnt_q;
        acc_base = sof ? '0 : acc_q;
        acc_sum  = {1'b0, acc_base} + (ACC_W+1)'(local_val);
        if (edge_flag) begin
            cnt_nx = (cnt_base == '1) ? cnt_base : cnt_base + 1'b1;
            acc_nx = acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
        end else begin
            cnt_nx = cnt_base;
            acc_nx = acc_base;
        end
    end

    // Frame mean candidate, clamped into 1..max; divisor guarded from zero.
    always_comb begin
        divisor = (cnt_nx == '0) ? ACC_W'(1) : ACC_W'(cnt_nx);
        q_full  = acc_nx / divisor;
        if (q_full > MEAN_MAX)    mean_nx = '1;
        else if (q_full == '0)    mean_nx = MEAN_W'(1);
        else                      mean_nx = q_full[MEAN_W-1:0];
    end

    // Update count and sum on each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (accept) begin
            cnt_q <= cnt_nx;
            acc_q <= acc_nx;
        end
    end

    // Register the mean at frame end when at least one edge pixel was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mean_q <= MEAN_W'(1);
        end else if (accept && eof && (cnt_nx != '0)) begin
            mean_q <= mean_nx;
        end
    end

    assign mean = mean_q;

    // R6: the mean never reaches zero.
    p_mean_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mean_q != '0);

    // R6: a frame with no edge pixels keeps the old mean.
    p_mean_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && eof && (cnt_nx == '0)) |=> (mean_q == $past(mean_q)));

    // R5: the edge count does not wrap within a frame.
    p_count_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sof && (cnt_q == '1)) |=> (cnt_q == '1));

    // R5: the sum does not wrap within a frame.
    p_acc_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sof && (acc_q == '1)) |=> (acc_q == '1));

endmodule

// File: rtl/asc_seq_div.sv
// Restoring divider, one quotient bit per cycle, fixed latency DVD_W.
// Assumes start only while idle and a nonzero divisor.
module asc_seq_div #(
    parameter int DVD_W = 7,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [DVD_W-1:0] quotient
);
    localparam int STEP_W = $clog2(DVD_W + 1);

    logic [DIV_W-1:0]  rem_q, div_q;
    logic [DVD_W-1:0]  quo_q, dvd_q, res_q, quo_nx;
    logic [STEP_W-1:0] step_q;
    logic              busy_q, done_q, ge;
    logic [DIV_W:0]    rem_sh, rem_diff;

    // One restoring step: shift in the next dividend bit and trial-subtract.
    always_comb begin
        rem_sh   = {rem_q, quo_q[DVD_W-1]};
        rem_diff = rem_sh - {1'b0, div_q};
        ge       = (rem_sh >= {1'b0, div_q});
        quo_nx   = {quo_q[DVD_W-2:0], ge};
    end

    // Load operands on start, then iterate until all bits are done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            div_q  <= '0;
            dvd_q  <= '0;
            res_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dvd_q  <= dividend;
                div_q  <= divisor;
                step_q <= STEP_W'(DVD_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= ge ? rem_diff[DIV_W-1:0] : rem_sh[DIV_W-1:0];
                quo_q  <= quo_nx;
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= quo_nx;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign quotient = res_q;

    // R8: a new division is only started while idle.
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

    // R6: the divisor handed over is never zero.
    p_div_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (divisor != '0));

    // R4: the result is the floor quotient of the latched operands.
    p_quotient_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((32'(res_q) * 32'(div_q) <= 32'(dvd_q)) &&
                  ((32'(res_q) + 32'd1) * 32'(div_q) > 32'(dvd_q))));

endmodule

// File: rtl/align_score_top.sv
// Per-orientation alignment scorer: weight lookup, 3x3 smoothing gated by
// the edge flag, frame statistics for a mean, and a multi-cycle division of
// each local value by the previous frame's mean. Assumes each frame begins
// with an sof pixel and ends with an eof pixel.
module align_score_top #(
    parameter int LINE_W    = 8,
    parameter int DIR_W     = 2,
    parameter int ALIGN_DIR = 1,
    parameter int W_CENTRE  = 8,
    parameter int W_NEAR    = 4,
    parameter int W_FAR     = 1,
    parameter int CNT_W     = 8,
    parameter int ACC_W     = 16,
    parameter int MEAN_W    = 8,
    localparam int SCORE_W  = $clog2(9 * W_CENTRE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DIR_W-1:0]   in_dir,
    input  logic               in_edge,
    input  logic               in_sof,
    input  logic               in_eof,
    output logic               out_valid,
    output logic [SCORE_W-1:0] out_score
);
    localparam int WGT_W = $clog2(W_CENTRE + 1);

    logic               accept, div_busy;
    logic [WGT_W-1:0]   weight;
    logic [SCORE_W-1:0] local_val;
    logic [MEAN_W-1:0]  mean;

    // Pixel handshake: take a pixel only while the divider is idle.
    assign in_ready = !div_busy;
    assign accept   = in_valid && in_ready;

    asc_weight #(
        .DIR_W(DIR_W), .ALIGN_DIR(ALIGN_DIR), .W_CENTRE(W_CENTRE),
        .W_NEAR(W_NEAR), .W_FAR(W_FAR), .WGT_W(WGT_W)
    ) i_weight (
        .dir_code(in_dir),
        .weight  (weight)
    );

    asc_window #(
        .LINE_W(LINE_W), .WGT_W(WGT_W), .W_MAX(W_CENTRE), .LOCAL_W(SCORE_W)
    ) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .sof      (in_sof),
        .edge_flag(in_edge),
        .weight   (weight),
        .local_val(local_val)
    );

    asc_frame_stats #(
        .CNT_W(CNT_W), .ACC_W(ACC_W), .MEAN_W(MEAN_W), .LOCAL_W(SCORE_W)
    ) i_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .sof      (in_sof),
        .eof      (in_eof),
        .edge_flag(in_edge),
        .local_val(local_val),
        .mean     (mean)
    );

    asc_seq_div #(
        .DVD_W(SCORE_W), .DIV_W(MEAN_W)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .dividend(local_val),
        .divisor (mean),
        .busy    (div_busy),
        .done    (out_valid),
        .quotient(out_score)
    );

    // R3: a non-edge pixel contributes a zero local value.
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_edge) |-> (local_val == '0));

    // R8: accepting a pixel drops ready on the next cycle.
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R8: a score appears together with ready returning.
    p_out_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

endmodule

// File: tb/test_align_score_top.sv
module test_align_score_top;
    localparam int LW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_dir = '0;
    logic       in_edge = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       out_valid;
    logic [6:0] out_score;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model state.
    int fw [0:2047];
    int pos = 0;
    int m_cnt = 0;
    int m_acc = 0;
    int m_mean = 1;

    align_score_top i_align_score_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dir(in_dir), .in_edge(in_edge), .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_score(out_score)
    );

    always #4 clk = ~clk;

    function automatic int wt(int d);
        int c;
        c = (d - 1 + 4) % 4;
        if (c == 3) c = 1;
        return (c == 0) ? 8 : ((c == 1) ? 4 : 1);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send(int d, bit e, bit s, bit f, string tag);
        int loc;
        int exp_score;
        int cyc;
        int q;
        if (s) pos = 0;
        fw[pos] = wt(d);
        loc = 0;
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                if (pos - r * LW - c >= 0) loc += fw[pos - r * LW - c];
            end
        end
        if (!e) loc = 0;
        exp_score = loc / m_mean;
        if (s) begin
            m_cnt = 0;
            m_acc = 0;
        end
        if (e) begin
            m_cnt = (m_cnt + 1 > 255) ? 255 : m_cnt + 1;
            m_acc = (m_acc + loc > 65535) ? 65535 : m_acc + loc;
        end
        if (f && m_cnt > 0) begin
            q = m_acc / m_cnt;
            if (q > 255) q = 255;
            if (q < 1) q = 1;
            m_mean = q;
        end
        pos++;

        @(negedge clk);
        in_valid = 1'b1;
        in_dir = 2'(d);
        in_edge = e;
        in_sof = s;
        in_eof = f;
        @(posedge clk);
        @(negedge clk);
        cyc = 0;
        // R9: junk presented while ready is low.
        in_dir = 2'($urandom % 4);
        in_edge = 1'($urandom);
        in_sof = 1'($urandom);
        in_eof = 1'($urandom);
        do begin
            @(negedge clk);
            cyc++;
            if (in_ready && !out_valid) begin
                check(1'b0, "R8", "ready during busy", 1, 0);
            end
        end while (!out_valid && cyc < 40);
        in_valid = 1'b0;
        check(cyc == 7, "R8", "latency", cyc, 7);
        check(out_score == 7'(exp_score), tag, "score", int'(out_score), exp_score);
    endtask

    // mode 0 random, 1 aligned edges, 2 far edges, 3 no edges
    task automatic frame(int len, int mode, string tag);
        int d;
        bit e;
        for (int i = 0; i < len; i++) begin
            case (mode)
                0: begin d = $urandom % 4; e = ($urandom % 3) != 0; end
                1: begin d = 1; e = 1'b1; end
                2: begin d = 3; e = 1'b1; end
                default: begin d = $urandom % 4; e = 1'b0; end
            endcase
            send(d, e, i == 0, i == len - 1, e ? tag : "R3");
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R8", "reset ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R8", "reset out_valid", int'(out_valid), 0);

        // R7: first frame uses mean 1.
        frame(LW * 3, 0, "R7");

        // R1: single-pixel frames, each preceded by a frame forcing mean 1.
        for (int d = 0; d < 4; d++) begin
            send(3, 1'b1, 1'b1, 1'b1, "R6");
            send(d, 1'b1, 1'b1, 1'b1, "R1");
        end

        // R2: window sums over random frames.
        frame(LW * 4, 0, "R2");
        frame(LW * 4, 0, "R2");

        // R6: empty frame keeps the mean.
        frame(LW * 2, 3, "R3");
        frame(LW * 2, 0, "R6");

        // R5: count saturation, then sum saturation with clamped mean.
        frame(300, 2, "R5");
        frame(LW * 2, 1, "R5");
        frame(1000, 1, "R5");
        frame(LW * 2, 1, "R6");

        // R4: normalisation by previous frame mean.
        frame(LW * 3, 0, "R4");
        frame(LW * 3, 0, "R4");

        // R9: further random frames with junk during every stall.
        frame(LW * 3, 0, "R9");

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule